// File: doc/BRIEF.md
# Memory Fault Capture and Interrupt Unit

This unit sits beside a memory controller and records accesses that went wrong. Three upstream detectors each flag a different kind of fault: an address that decodes to no memory, an access to an unmapped page of the translation aperture, and a security violation. Each flag carries the ID of the requesting client, whether the access was a write, and the faulting address. The security detector also gives a subtype bit. For each kind of fault the unit stores a capture word and the address, and sets a pending bit. A single interrupt line goes high while any pending bit is also enabled in the mask.

Software reads the capture words and addresses over a simple register bus and acknowledges a fault by writing a one to its pending bit. Each capture word keeps the first fault of its kind until software acknowledges it. A new fault that arrives in the same cycle as the acknowledge is kept, so no fault is lost in that race.

Fault inputs are one-cycle valid strobes with no ready signal. The unit accepts one fault per kind on every cycle and never applies back-pressure. An upstream detector therefore never waits. A fault that arrives while a capture is held still sets the pending bit, but its details are dropped. Register reads return data one cycle after the request, together with a single-cycle valid strobe. Register writes take effect at the clock edge on which they are presented.

Top module: `mfc_fault_capture`

## Requirements
- R1: After reset, the pending bits, the mask, all capture words and all captured addresses are zero, and `irq` is low.
- R2: A decode fault stores a capture word at offset 0x10 with the client ID in bits 5:0 and bit 31 set for a write. All other bits are zero.
- R3: A page fault stores a capture word at offset 0x18 with the client ID in bits 6:1 and bit 0 set for a write. All other bits are zero.
- R4: A security fault stores a capture word at offset 0x20 with the client ID in bits 5:0, bit 31 set for a write and bit 30 equal to the subtype input. All other bits are zero.
- R5: The faulting address of each kind reads back at the offset four above its capture word: 0x14, 0x1C and 0x24.
- R6: A fault sets its pending bit (decode bit 0, page bit 1, security bit 2 of the register at 0x00) on the next edge. `irq` is high exactly while some pending bit is also set in the mask register.
- R7: Writing to 0x00 clears each pending bit whose written bit is one and leaves the bits written as zero unchanged.
- R8: While a pending bit is set, later faults of the same kind do not change its capture word or address.
- R9: If a fault arrives in the same cycle as a write that clears its pending bit, the bit stays set and the new fault's word and address are captured.
- R10: Writes to the capture word and address offsets are ignored.
- R11: The mask register at 0x04 holds bits 2:0 and reads zero above them. Reads of unmapped offsets return zero.
- R12: A read presented in one cycle returns its data on `bus_rdata` in the next cycle, with `bus_rvalid` high for exactly that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with `bus_rvalid` |
| bus_rvalid | output | 1 | Read data valid, one cycle after `bus_rd` |
| dec_vld | input | 1 | Decode fault strobe |
| dec_client | input | 6 | Decode fault client ID |
| dec_write | input | 1 | Decode fault was a write |
| dec_addr | input | 32 | Decode fault address |
| pg_vld | input | 1 | Aperture page fault strobe |
| pg_client | input | 6 | Page fault client ID |
| pg_write | input | 1 | Page fault was a write |
| pg_addr | input | 32 | Page fault address |
| sec_vld | input | 1 | Security fault strobe |
| sec_client | input | 6 | Security fault client ID |
| sec_write | input | 1 | Security fault was a write |
| sec_kind | input | 1 | Security fault subtype |
| sec_addr | input | 32 | Security fault address |
| irq | output | 1 | Interrupt, high while a masked pending bit is set |

## Verification
On every cycle the assertions check four things. A fault always sets its pending bit. A pending bit never rises without a fault. An acknowledge clears the bit unless a fault arrives in the same cycle. A held capture word stays stable. They also check the one-cycle read strobe and that `irq` only rises after a fault or a mask write.

Some behaviour can only be shown by the bench's scenarios. These are the exact bit packing of each capture word, the address at the following offset, and which fault's details survive the clear-versus-fault race. The same holds for read-only and unmapped offsets and the masking of upper mask bits. The bench compares these against its reference model.

// File: rtl/mfc_pkg.sv
`timescale 1ns/1ps
package mfc_pkg;
  localparam int N_SRC    = 3;
  localparam int CLIENT_W = 6;
  localparam int DATA_W   = 32;

  typedef enum logic [1:0] {
    SRC_DECODE = 2'd0,
    SRC_PAGE   = 2'd1,
    SRC_SECURE = 2'd2
  } src_e;

  localparam logic [7:0] OFS_PENDING  = 8'h00;
  localparam logic [7:0] OFS_MASK     = 8'h04;
  localparam logic [7:0] OFS_CAP_BASE = 8'h10;
  localparam logic [7:0] CAP_STRIDE   = 8'h08;
  localparam logic [7:0] ADDR_SKEW    = 8'h04;

  typedef struct packed {
    logic                vld;
    logic [CLIENT_W-1:0] client;
    logic                write;
    logic                subtype;
    logic [DATA_W-1:0]   addr;
  } fault_t;

  // Per-kind packing of the capture word.
  function automatic logic [DATA_W-1:0] pack_capture(src_e kind, fault_t f);
    logic [DATA_W-1:0] w;
    w = '0;
    case (kind)
      SRC_DECODE: begin
        w[CLIENT_W-1:0] = f.client;
        w[DATA_W-1]     = f.write;
      end
      SRC_PAGE: begin
        w[CLIENT_W:1]   = f.client;
        w[0]            = f.write;
      end
      default: begin
        w[CLIENT_W-1:0] = f.client;
        w[DATA_W-1]     = f.write;
        w[DATA_W-2]     = f.subtype;
      end
    endcase
    return w;
  endfunction

  function automatic logic [7:0] cap_offset(int idx);
    return OFS_CAP_BASE + CAP_STRIDE * 8'(idx);
  endfunction
endpackage

// File: rtl/mfc_capture_slot.sv
`timescale 1ns/1ps
module mfc_capture_slot
  import mfc_pkg::*;
#(
  parameter src_e KIND = SRC_DECODE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fault_t            fault_i,
  input  logic              pending_i,
  input  logic              clr_i,
  output logic [DATA_W-1:0] word_o,
  output logic [DATA_W-1:0] addr_o
);
  logic              load;
  logic [DATA_W-1:0] word_d;

  // Take a fault when nothing is held, or when the held one is released now.
  assign load   = fault_i.vld && (!pending_i || clr_i);
  assign word_d = pack_capture(KIND, fault_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_o <= '0;
      addr_o <= '0;
    end else if (load) begin
      word_o <= word_d;
      addr_o <= fault_i.addr;
    end
  end
endmodule

// File: rtl/mfc_irq_ctrl.sv
`timescale 1ns/1ps
module mfc_irq_ctrl
  import mfc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] fault_vld_i,
  input  logic [N_SRC-1:0] clr_i,
  input  logic             mask_we_i,
  input  logic [N_SRC-1:0] mask_d_i,
  output logic [N_SRC-1:0] pending_o,
  output logic [N_SRC-1:0] mask_o,
  output logic             irq_o
);
  logic [N_SRC-1:0] pending_d;

  // A new fault wins over an acknowledge in the same cycle.
  always_comb begin
    for (int i = 0; i < N_SRC; i++) begin
      if (fault_vld_i[i])  pending_d[i] = 1'b1;
      else if (clr_i[i])   pending_d[i] = 1'b0;
      else                 pending_d[i] = pending_o[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_o <= '0;
      mask_o    <= '0;
    end else begin
      pending_o <= pending_d;
      if (mask_we_i) mask_o <= mask_d_i;
    end
  end

  assign irq_o = |(pending_o & mask_o);
endmodule

// File: rtl/mfc_regbus.sv
`timescale 1ns/1ps
module mfc_regbus
  import mfc_pkg::*;
#(
  parameter int BUS_AW = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         bus_wr,
  input  logic                         bus_rd,
  input  logic [BUS_AW-1:0]            bus_addr,
  input  logic [DATA_W-1:0]            bus_wdata,
  input  logic [N_SRC-1:0]             pending_i,
  input  logic [N_SRC-1:0]             mask_i,
  input  logic [N_SRC-1:0][DATA_W-1:0] cap_word_i,
  input  logic [N_SRC-1:0][DATA_W-1:0] cap_addr_i,
  output logic [N_SRC-1:0]             clr_o,
  output logic                         mask_we_o,
  output logic [N_SRC-1:0]             mask_d_o,
  output logic [DATA_W-1:0]            rdata_o,
  output logic                         rvalid_o
);
  localparam logic [BUS_AW-1:0] A_PENDING = BUS_AW'(OFS_PENDING);
  localparam logic [BUS_AW-1:0] A_MASK    = BUS_AW'(OFS_MASK);

  logic [N_SRC-1:0] hit_word, hit_addr;
  logic [DATA_W-1:0] rd_mux;

  for (genvar g = 0; g < N_SRC; g++) begin : g_dec
    localparam logic [BUS_AW-1:0] A_WORD = BUS_AW'(cap_offset(g));
    localparam logic [BUS_AW-1:0] A_ADDR = BUS_AW'(cap_offset(g) + ADDR_SKEW);
    assign hit_word[g] = (bus_addr == A_WORD);
    assign hit_addr[g] = (bus_addr == A_ADDR);
  end

  assign clr_o     = (bus_wr && bus_addr == A_PENDING) ? bus_wdata[N_SRC-1:0] : '0;
  assign mask_we_o = bus_wr && (bus_addr == A_MASK);
  assign mask_d_o  = bus_wdata[N_SRC-1:0];

  always_comb begin
    rd_mux = '0;
    if (bus_addr == A_PENDING) rd_mux = DATA_W'(pending_i);
    if (bus_addr == A_MASK)    rd_mux = DATA_W'(mask_i);
    for (int i = 0; i < N_SRC; i++) begin
      if (hit_word[i]) rd_mux = cap_word_i[i];
      if (hit_addr[i]) rd_mux = cap_addr_i[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= bus_rd;
      if (bus_rd) rdata_o <= rd_mux;
    end
  end
endmodule

// File: rtl/mfc_fault_capture.sv
`timescale 1ns/1ps
module mfc_fault_capture
  import mfc_pkg::*;
#(
  parameter int BUS_AW = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [BUS_AW-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                bus_rvalid,
  input  logic                dec_vld,
  input  logic [CLIENT_W-1:0] dec_client,
  input  logic                dec_write,
  input  logic [DATA_W-1:0]   dec_addr,
  input  logic                pg_vld,
  input  logic [CLIENT_W-1:0] pg_client,
  input  logic                pg_write,
  input  logic [DATA_W-1:0]   pg_addr,
  input  logic                sec_vld,
  input  logic [CLIENT_W-1:0] sec_client,
  input  logic                sec_write,
  input  logic                sec_kind,
  input  logic [DATA_W-1:0]   sec_addr,
  output logic                irq
);
  fault_t [N_SRC-1:0]             flt;
  logic   [N_SRC-1:0]             fault_vld;
  logic   [N_SRC-1:0]             clr_bits;
  logic   [N_SRC-1:0]             status_q;
  logic   [N_SRC-1:0]             mask_q;
  logic                           mask_we;
  logic   [N_SRC-1:0]             mask_d;
  logic   [N_SRC-1:0][DATA_W-1:0] cap_word;
  logic   [N_SRC-1:0][DATA_W-1:0] cap_addr;

  assign flt[SRC_DECODE] = '{vld: dec_vld, client: dec_client, write: dec_write,
                             subtype: 1'b0, addr: dec_addr};
  assign flt[SRC_PAGE]   = '{vld: pg_vld, client: pg_client, write: pg_write,
                             subtype: 1'b0, addr: pg_addr};
  assign flt[SRC_SECURE] = '{vld: sec_vld, client: sec_client, write: sec_write,
                             subtype: sec_kind, addr: sec_addr};

  for (genvar g = 0; g < N_SRC; g++) begin : g_slot
    assign fault_vld[g] = flt[g].vld;
    mfc_capture_slot #(.KIND(src_e'(g))) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .fault_i   (flt[g]),
      .pending_i (status_q[g]),
      .clr_i     (clr_bits[g]),
      .word_o    (cap_word[g]),
      .addr_o    (cap_addr[g])
    );
  end

  mfc_irq_ctrl u_irq (
    .clk         (clk),
    .rst_n       (rst_n),
    .fault_vld_i (fault_vld),
    .clr_i       (clr_bits),
    .mask_we_i   (mask_we),
    .mask_d_i    (mask_d),
    .pending_o   (status_q),
    .mask_o      (mask_q),
    .irq_o       (irq)
  );

  mfc_regbus #(.BUS_AW(BUS_AW)) u_bus (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .pending_i  (status_q),
    .mask_i     (mask_q),
    .cap_word_i (cap_word),
    .cap_addr_i (cap_addr),
    .clr_o      (clr_bits),
    .mask_we_o  (mask_we),
    .mask_d_o   (mask_d),
    .rdata_o    (bus_rdata),
    .rvalid_o   (bus_rvalid)
  );
endmodule

// File: rtl/mfc_fault_capture_chk.sv
`timescale 1ns/1ps
module mfc_fault_capture_chk
  import mfc_pkg::*;
#(
  parameter int BUS_AW = 8
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         bus_wr,
  input logic                         bus_rd,
  input logic [BUS_AW-1:0]            bus_addr,
  input logic [DATA_W-1:0]            bus_wdata,
  input logic                         bus_rvalid,
  input logic [N_SRC-1:0]             fault_vld,
  input logic [N_SRC-1:0]             status,
  input logic [N_SRC-1:0][DATA_W-1:0] cap_word,
  input logic                         irq
);
  logic ack_wr, mask_wr;
  assign ack_wr  = bus_wr && (bus_addr == BUS_AW'(OFS_PENDING));
  assign mask_wr = bus_wr && (bus_addr == BUS_AW'(OFS_MASK));

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    AST_FAULT_SETS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      fault_vld[g] |=> status[g]);                                         // R6
    AST_NO_SPURIOUS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[g]) |-> $past(fault_vld[g]));                           // R6
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_wr && bus_wdata[g] && !fault_vld[g]) |=> !status[g]);           // R7
    AST_HELD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      (status[g] && !(ack_wr && bus_wdata[g])) |=> $stable(cap_word[g]));  // R8
    AST_RACE_KEEPS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_vld[g] && ack_wr && bus_wdata[g]) |=> status[g]);             // R9
  end

  AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(fault_vld != '0 || mask_wr));                     // R6
  AST_READ_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);                                                // R12
  AST_NO_STRAY_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !bus_rvalid);                                              // R12
endmodule

bind mfc_fault_capture mfc_fault_capture_chk #(.BUS_AW(BUS_AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rvalid (bus_rvalid),
  .fault_vld  (fault_vld),
  .status     (status_q),
  .cap_word   (cap_word),
  .irq        (irq)
);

// File: tb/mfc_fault_capture_tb_top.sv
`timescale 1ns/1ps
module mfc_fault_capture_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid, irq;
  logic        f_vld [3];
  logic [5:0]  f_cl  [3];
  logic        f_wr  [3];
  logic [31:0] f_ad  [3];
  logic        f_sub = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mfc_fault_capture dut_i (
    .clk(clk), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .dec_vld(f_vld[0]), .dec_client(f_cl[0]), .dec_write(f_wr[0]), .dec_addr(f_ad[0]),
    .pg_vld(f_vld[1]), .pg_client(f_cl[1]), .pg_write(f_wr[1]), .pg_addr(f_ad[1]),
    .sec_vld(f_vld[2]), .sec_client(f_cl[2]), .sec_write(f_wr[2]), .sec_kind(f_sub),
    .sec_addr(f_ad[2]), .irq(irq)
  );

  // Expected capture word per kind (R2, R3, R4).
  function automatic logic [31:0] exp_word(int k, logic [5:0] id, logic wr, logic sub);
    if (k == 0)      return {wr, 25'b0, id};
    else if (k == 1) return {25'b0, id, wr};
    else             return {wr, sub, 24'b0, id};
  endfunction

  // Behavioural reference model
  logic [2:0]  m_pend, m_mask;
  logic [31:0] m_word [3];
  logic [31:0] m_addr [3];
  logic        m_rvalid;
  logic [31:0] m_rdata;

  function automatic logic [31:0] m_read(logic [7:0] a);
    case (a)
      8'h00: return {29'b0, m_pend};
      8'h04: return {29'b0, m_mask};
      8'h10: return m_word[0];
      8'h14: return m_addr[0];
      8'h18: return m_word[1];
      8'h1C: return m_addr[1];
      8'h20: return m_word[2];
      8'h24: return m_addr[2];
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pend = '0; m_mask = '0; m_rvalid = 1'b0; m_rdata = '0;
      for (int i = 0; i < 3; i++) begin m_word[i] = '0; m_addr[i] = '0; end
    end else begin
      logic [2:0] ack;
      m_rvalid = bus_rd;
      if (bus_rd) m_rdata = m_read(bus_addr);
      ack = (bus_wr && bus_addr == 8'h00) ? bus_wdata[2:0] : 3'b0;
      for (int i = 0; i < 3; i++) begin
        if (f_vld[i]) begin
          if (!m_pend[i] || ack[i]) begin
            m_word[i] = exp_word(i, f_cl[i], f_wr[i], f_sub);
            m_addr[i] = f_ad[i];
          end
          m_pend[i] = 1'b1;
        end else if (ack[i]) m_pend[i] = 1'b0;
      end
      if (bus_wr && bus_addr == 8'h04) m_mask = bus_wdata[2:0];
    end
  end

  // Per-cycle comparison against the model (R6, R12)
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (irq !== |(m_pend & m_mask)) begin
        errors++;
        $display("FAIL R6 model: irq got %b exp %b", irq, |(m_pend & m_mask));
      end
      checks++;
      if (bus_rvalid !== m_rvalid) begin
        errors++;
        $display("FAIL R12 model: rvalid got %b exp %b", bus_rvalid, m_rvalid);
      end
      if (m_rvalid) begin
        checks++;
        if (bus_rdata !== m_rdata) begin
          errors++;
          $display("FAIL R12 model: rdata got %h exp %h", bus_rdata, m_rdata);
        end
      end
    end
  end

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic read_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    checks++;
    if (bus_rdata !== exp || bus_rvalid !== 1'b1) begin
      errors++;
      $display("FAIL %s: addr %h got %h (rvalid %b) exp %h", tag, a, bus_rdata, bus_rvalid, exp);
    end
  endtask

  task automatic set_fault(input int k, input logic [5:0] id, input logic wr,
                           input logic sub, input logic [31:0] ad);
    f_vld[k] = 1'b1; f_cl[k] = id; f_wr[k] = wr; f_ad[k] = ad;
    if (k == 2) f_sub = sub;
  endtask

  task automatic fault_pulse(input int k, input logic [5:0] id, input logic wr,
                             input logic sub, input logic [31:0] ad);
    @(negedge clk);
    set_fault(k, id, wr, sub, ad);
    @(negedge clk);
    f_vld[k] = 1'b0;
  endtask

  task automatic irq_chk(input logic exp, input string tag);
    checks++;
    if (irq !== exp) begin
      errors++;
      $display("FAIL %s: irq got %b exp %b", tag, irq, exp);
    end
  endtask

  initial begin
    for (int i = 0; i < 3; i++) begin f_vld[i] = 0; f_cl[i] = 0; f_wr[i] = 0; f_ad[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    irq_chk(1'b0, "R1 irq");
    read_chk(8'h00, 32'h0, "R1 pending");
    read_chk(8'h04, 32'h0, "R1 mask");
    for (int i = 0; i < 3; i++) begin
      read_chk(8'(8'h10 + 8 * i), 32'h0, "R1 capture word");
      read_chk(8'(8'h14 + 8 * i), 32'h0, "R1 capture addr");
    end

    // R11: mask width and unmapped offsets
    bus_write(8'h04, 32'hFFFF_FFFF);
    read_chk(8'h04, 32'h7, "R11 mask upper bits");
    read_chk(8'h40, 32'h0, "R11 unmapped");
    read_chk(8'h08, 32'h0, "R11 unmapped gap");

    // R2, R5, R6: decode fault
    fault_pulse(0, 6'h2A, 1'b1, 1'b0, 32'h1234_5678);
    irq_chk(1'b1, "R6 irq after decode fault");
    read_chk(8'h10, 32'h8000_002A, "R2 decode word");
    read_chk(8'h14, 32'h1234_5678, "R5 decode addr");
    read_chk(8'h00, 32'h1, "R6 pending decode");

    // R3, R5: page fault
    fault_pulse(1, 6'h15, 1'b1, 1'b0, 32'hCAFE_0040);
    read_chk(8'h18, 32'h0000_002B, "R3 page word");
    read_chk(8'h1C, 32'hCAFE_0040, "R5 page addr");

    // R4, R5: security fault, read access, subtype 1
    fault_pulse(2, 6'h3F, 1'b0, 1'b1, 32'h0000_F00C);
    read_chk(8'h20, 32'h4000_003F, "R4 security word");
    read_chk(8'h24, 32'h0000_F00C, "R5 security addr");
    read_chk(8'h00, 32'h7, "R6 pending all");

    // R8: later decode fault while pending is held off
    fault_pulse(0, 6'h01, 1'b0, 1'b0, 32'hAAAA_AAAA);
    read_chk(8'h10, 32'h8000_002A, "R8 word held");
    read_chk(8'h14, 32'h1234_5678, "R8 addr held");

    // R10: writes to capture offsets ignored
    bus_write(8'h10, 32'hDEAD_BEEF);
    bus_write(8'h24, 32'hDEAD_BEEF);
    read_chk(8'h10, 32'h8000_002A, "R10 word read-only");
    read_chk(8'h24, 32'h0000_F00C, "R10 addr read-only");

    // R7: acknowledge one bit only
    bus_write(8'h00, 32'h2);
    read_chk(8'h00, 32'h5, "R7 partial ack");
    irq_chk(1'b1, "R7 irq still set");
    bus_write(8'h00, 32'h5);
    read_chk(8'h00, 32'h0, "R7 full ack");
    irq_chk(1'b0, "R7 irq cleared");

    // R6: masked-off source keeps irq low
    bus_write(8'h04, 32'h0);
    fault_pulse(1, 6'h07, 1'b0, 1'b0, 32'h0000_1000);
    read_chk(8'h00, 32'h2, "R6 pending unmasked");
    irq_chk(1'b0, "R6 irq masked off");
    bus_write(8'h04, 32'h2);
    irq_chk(1'b1, "R6 irq after mask enable");

    // R9: fault and acknowledge in the same cycle
    fault_pulse(0, 6'h05, 1'b1, 1'b0, 32'h0000_0500);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 8'h00; bus_wdata = 32'h1;
    set_fault(0, 6'h09, 1'b0, 1'b0, 32'h0000_0900);
    @(negedge clk);
    bus_wr = 1'b0; f_vld[0] = 1'b0;
    read_chk(8'h00, 32'h3, "R9 pending kept");
    read_chk(8'h10, 32'h0000_0009, "R9 new word captured");
    read_chk(8'h14, 32'h0000_0900, "R9 new addr captured");

    // R12: read strobe timing, then idle
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 8'h04;
    @(negedge clk);
    bus_rd = 1'b0;
    checks++;
    if (bus_rvalid !== 1'b1 || bus_rdata !== 32'h2) begin
      errors++;
      $display("FAIL R12 read timing: got %b/%h exp 1/%h", bus_rvalid, bus_rdata, 32'h2);
    end
    @(negedge clk);
    checks++;
    if (bus_rvalid !== 1'b0) begin
      errors++;
      $display("FAIL R12 rvalid width: got %b exp 0", bus_rvalid);
    end

    repeat (4) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, got timeout exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule